// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control half of a small accumulator machine. It holds a micro-program counter and a fixed sixteen-entry microcode store. Every cycle it drives thirteen control strobes that steer a shared-bus datapath: one read strobe picks the bus driver, and the write strobes pick the registers or the memory word that capture the bus at the clock edge. The datapath sends back the three opcode bits of the instruction register and a flag that is high while the accumulator is nonzero. From these the sequencer runs a fetch, decode and execute routine for each of eight instruction codes and then returns to micro-address 0.

Each microword holds the strobes, a two-bit test code and a four-bit target. One modulo-16 adder forms the next micro-address. It adds 1 to the current address, or adds 3 to the opcode for the dispatch, or adds zero to the target. The conditional form takes the target only while the flag is high. The strobes come straight from a registered microcode read, and a registered boundary output marks the first cycle of every instruction.

For the requirements below, the attached datapath works as follows. It has a word width of N+3 bits, and memory is addressed by the low N bits of the address register. The opcode is IR bits [N+2:N]. The buffer register captures ARG+bus in every cycle. With the sub strobe it captures ARG-bus instead, and with the inc strobe it captures bus+1.

Top module: `useq_top`

## Requirements
- R1: A synchronous active-high reset forces micro-address 0. The clock edge after reset is seen leaves the boundary output high and the strobes showing the first fetch step. This holds even when reset arrives in the middle of an instruction.
- R2: The strobe vector bits are: 12 memory write, 11 memory read, 10 address-register write, 9 PC write, 8 PC read, 7 ACC write, 6 ACC read, 5 IR write, 4 IR read, 3 ARG write, 2 ALU subtract, 1 ALU increment, 0 buffer read. In the boundary cycle the strobes are exactly PC read and address write (0x500). In the cycle after it they are exactly memory read and IR write (0x820).
- R3: At most one of the five read strobes (bits 11, 8, 6, 4, 0) is high in any cycle.
- R4: Test code step gives the current address plus 1. Conditional gives the target when the accumulator-nonzero flag is high and the current address plus 1 otherwise. Jump gives the target. Micro-address 0 is always followed by 1. Micro-address 3 is followed by 10 when the flag is high and by 4 when it is low.
- R5: Micro-address 2 is followed by the opcode plus 3, taken modulo 16.
- R6: From a boundary, the next boundary comes after this many cycles. Opcode 0 takes 5 cycles with ACC zero and 6 cycles otherwise. Opcode 1 takes 4. Opcodes 2 and 3 take 8. Opcodes 4, 5 and 6 take 6. Opcode 7 takes 5.
- R7: Opcode 0 loads the whole instruction word into the PC when ACC is zero and otherwise increments the PC. Opcode 1 always loads the whole instruction word into the PC.
- R8: Opcode 2 sets ACC to ACC+M, opcode 3 sets ACC to ACC-M, and opcode 4 sets ACC to M, where M is the memory word at the instruction's low N bits. Opcode 5 writes ACC to that word. The memory write strobe is high only at micro-address 8.
- R9: The boundary output is high exactly in the cycles where the micro-address is 0.
- R10: Every opcode other than 0 and 1 increments the PC modulo 2^(N+3). Opcodes 6 and 7 change nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | OPC_W (3) | Opcode field of the instruction register |
| acc_nz_i | input | 1 | High while the accumulator is nonzero |
| ctl_o | output | CTL_W (13) | Control strobes, bit order as in R2 |
| at_boundary_o | output | 1 | High in the first cycle of each instruction |

## Verification
The hard case to reach is the conditional step at micro-address 3. Both of its outcomes have to be hit, and the flag has to be sampled at the right time. The flag depends on what earlier instructions left in the accumulator, and the sequencer cannot set it by itself. The bench therefore surrounds the sequencer with a behavioural datapath and memory. A directed sweep preloads the accumulator as zero or nonzero under every opcode and every operand address. Randomly seeded programs, some of which overwrite their own code and wrap the PC, are then checked against an instruction-level model at each boundary. These runs are cut short by a reset that lands in the middle of an instruction.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int UA_W  = 4;
  localparam int OPC_W = 3;
  localparam int CTL_W = 13;

  // strobe bit positions inside the control vector
  localparam int S_MWR  = 12;
  localparam int S_MRD  = 11;
  localparam int S_MARW = 10;
  localparam int S_PCW  = 9;
  localparam int S_PCR  = 8;
  localparam int S_ACW  = 7;
  localparam int S_ACR  = 6;
  localparam int S_IRW  = 5;
  localparam int S_IRR  = 4;
  localparam int S_ARGW = 3;
  localparam int S_SUB  = 2;
  localparam int S_INC  = 1;
  localparam int S_BUFR = 0;

  // upper bit: take a non-sequential path; lower bit: use the target field
  typedef enum logic [1:0] {
    T_STEP = 2'b00,
    T_COND = 2'b01,
    T_DISP = 2'b10,
    T_JUMP = 2'b11
  } test_e;

  typedef struct packed {
    logic [CTL_W-1:0] ctl;
    test_e            tst;
    logic [UA_W-1:0]  tgt;
  } uword_t;

  function automatic logic [CTL_W-1:0] sb(input int pos);
    logic [CTL_W-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  function automatic uword_t mk(input logic [CTL_W-1:0] c, input test_e t,
                                input logic [UA_W-1:0] g);
    uword_t w;
    w.ctl = c;
    w.tst = t;
    w.tgt = g;
    return w;
  endfunction

  // fixed microprogram
  function automatic uword_t ucode(input logic [UA_W-1:0] a);
    uword_t w;
    case (a)
      4'd0:    w = mk(sb(S_PCR) | sb(S_MARW), T_STEP, 4'd0);   // fetch: address <- PC
      4'd1:    w = mk(sb(S_MRD) | sb(S_IRW),  T_STEP, 4'd0);   // fetch: IR <- mem
      4'd2:    w = mk(sb(S_IRR) | sb(S_MARW), T_DISP, 4'd0);   // decode
      4'd3:    w = mk('0,                     T_COND, 4'd10);  // zero test
      4'd4:    w = mk(sb(S_IRR) | sb(S_PCW),  T_JUMP, 4'd0);   // PC <- IR
      4'd5:    w = mk(sb(S_ACR) | sb(S_ARGW), T_JUMP, 4'd12);  // add operand stage
      4'd6:    w = mk(sb(S_ACR) | sb(S_ARGW), T_JUMP, 4'd13);  // sub operand stage
      4'd7:    w = mk(sb(S_MRD) | sb(S_ACW),  T_JUMP, 4'd10);  // load
      4'd8:    w = mk(sb(S_ACR) | sb(S_MWR),  T_JUMP, 4'd10);  // store
      4'd9:    w = mk('0,                     T_STEP, 4'd0);   // idle
      4'd10:   w = mk(sb(S_PCR) | sb(S_INC),  T_STEP, 4'd0);   // buffer <- PC+1
      4'd11:   w = mk(sb(S_BUFR) | sb(S_PCW), T_JUMP, 4'd0);   // PC <- buffer
      4'd12:   w = mk(sb(S_MRD),              T_JUMP, 4'd14);  // buffer <- ARG+mem
      4'd13:   w = mk(sb(S_MRD) | sb(S_SUB),  T_STEP, 4'd0);   // buffer <- ARG-mem
      4'd14:   w = mk(sb(S_BUFR) | sb(S_ACW), T_JUMP, 4'd10);  // ACC <- buffer
      default: w = mk('0,                     T_JUMP, 4'd0);   // spare entry
    endcase
    return w;
  endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int AW = useq_pkg::UA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  output uword_t        word_o
);

  // synchronous read; the reset value is the entry at address 0
  always_ff @(posedge clk) begin
    if (rst) word_o <= ucode('0);
    else     word_o <= ucode(addr_i);
  end

endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
  import useq_pkg::*;
#(
  parameter int UA_W      = useq_pkg::UA_W,
  parameter int OPC_W     = useq_pkg::OPC_W,
  parameter int DISP_BASE = 3
) (
  input  logic [UA_W-1:0]  mpc_i,
  input  test_e            test_i,
  input  logic [UA_W-1:0]  tgt_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             flag_i,
  output logic [UA_W-1:0]  nxt_o
);

  logic            leave;
  logic            use_tgt;
  logic [UA_W-1:0] base;
  logic [UA_W-1:0] addend;

  assign use_tgt = test_i[0];
  assign leave   = test_i[1] | (use_tgt & flag_i);

  always_comb begin
    if (leave) begin
      base   = use_tgt ? tgt_i : UA_W'(opcode_i);
      addend = use_tgt ? '0 : UA_W'(DISP_BASE);
    end else begin
      base   = mpc_i;
      addend = UA_W'(1);
    end
  end

  // single shared adder, wraps modulo 2^UA_W
  assign nxt_o = base + addend;

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int UA_W      = useq_pkg::UA_W,
  parameter int OPC_W     = useq_pkg::OPC_W,
  parameter int CTL_W     = useq_pkg::CTL_W,
  parameter int DISP_BASE = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             acc_nz_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic             at_boundary_o
);

  logic [UA_W-1:0] mpc_q;
  logic [UA_W-1:0] mpc_nxt;
  uword_t          word_q;
  logic            bnd_q;

  useq_rom #(.AW(UA_W)) u_rom (
    .clk    (clk),
    .rst    (rst),
    .addr_i (mpc_nxt),
    .word_o (word_q)
  );

  useq_nextaddr #(
    .UA_W      (UA_W),
    .OPC_W     (OPC_W),
    .DISP_BASE (DISP_BASE)
  ) u_nxt (
    .mpc_i    (mpc_q),
    .test_i   (word_q.tst),
    .tgt_i    (word_q.tgt),
    .opcode_i (opcode_i),
    .flag_i   (acc_nz_i),
    .nxt_o    (mpc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mpc_q <= '0;
      bnd_q <= 1'b1;
    end else begin
      mpc_q <= mpc_nxt;
      bnd_q <= (mpc_nxt == '0);
    end
  end

  assign ctl_o         = word_q.ctl;
  assign at_boundary_o = bnd_q;

endmodule

// File: rtl/useq_chk.sv
module useq_chk
  import useq_pkg::*;
#(
  parameter int UA_W  = useq_pkg::UA_W,
  parameter int OPC_W = useq_pkg::OPC_W,
  parameter int CTL_W = useq_pkg::CTL_W
) (
  input logic             clk,
  input logic             rst,
  input logic [OPC_W-1:0] opcode,
  input logic             acc_nz,
  input logic [UA_W-1:0]  mpc,
  input logic [CTL_W-1:0] ctl,
  input logic             bnd
);

  // R1
  reset_home_chk: assert property (@(posedge clk)
    rst |=> (mpc == '0) && bnd);

  // R3
  one_reader_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({ctl[S_MRD], ctl[S_PCR], ctl[S_ACR], ctl[S_IRR], ctl[S_BUFR]}) <= 1);

  // R4
  fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mpc == UA_W'(0)) |=> (mpc == UA_W'(1)));

  // R4
  cond_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (mpc == UA_W'(3)) && acc_nz |=> (mpc == UA_W'(10)));

  // R4
  cond_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (mpc == UA_W'(3)) && !acc_nz |=> (mpc == UA_W'(4)));

  // R5
  dispatch_chk: assert property (@(posedge clk) disable iff (rst)
    (mpc == UA_W'(2)) |=> (mpc == UA_W'($past(opcode)) + UA_W'(3)));

  // R8
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    ctl[S_MWR] |-> (mpc == UA_W'(8)));

  // R9
  boundary_chk: assert property (@(posedge clk) disable iff (rst)
    bnd == (mpc == '0));

endmodule

bind useq_top useq_chk #(.UA_W(UA_W), .OPC_W(OPC_W), .CTL_W(CTL_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .opcode (opcode_i),
  .acc_nz (acc_nz_i),
  .mpc    (mpc_q),
  .ctl    (ctl_o),
  .bnd    (at_boundary_o)
);

// File: tb/tb_useq_top.sv
`timescale 1ns/1ps
module tb_useq_top;

  localparam int N  = 3;
  localparam int W  = N + 3;
  localparam int MD = 1 << N;
  localparam logic [12:0] FETCH0 = 13'h500;  // PC read + address write
  localparam logic [12:0] FETCH1 = 13'h820;  // mem read + IR write

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  opcode;
  logic        acc_nz;
  logic [12:0] ctl;
  logic        bnd;

  always #2.5 clk = ~clk;

  useq_top dut (
    .clk           (clk),
    .rst           (rst),
    .opcode_i      (opcode),
    .acc_nz_i      (acc_nz),
    .ctl_o         (ctl),
    .at_boundary_o (bnd)
  );

  // behavioural datapath around the sequencer
  logic [W-1:0] mem [MD];
  logic [W-1:0] ld_img [MD];
  logic [W-1:0] ld_acc;
  logic [W-1:0] mar, pc, acc, ir, arg, bufr, bus;

  assign opcode = ir[W-1:N];
  assign acc_nz = (acc != '0);
  assign bus = ctl[11] ? mem[mar[N-1:0]] :
               ctl[8]  ? pc  :
               ctl[6]  ? acc :
               ctl[4]  ? ir  :
               ctl[0]  ? bufr : '0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MD; i++) mem[i] <= ld_img[i];
      pc <= '0; acc <= ld_acc; mar <= '0; ir <= '0; arg <= '0; bufr <= '0;
    end else begin
      if (ctl[12]) mem[mar[N-1:0]] <= bus;
      if (ctl[10]) mar <= bus;
      if (ctl[9])  pc  <= bus;
      if (ctl[7])  acc <= bus;
      if (ctl[5])  ir  <= bus;
      if (ctl[3])  arg <= bus;
      bufr <= ctl[1] ? bus + 6'd1 : (ctl[2] ? arg - bus : arg + bus);
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // instruction-level reference model
  logic [W-1:0] m_mem [MD];
  logic [W-1:0] m_pc, m_acc;

  task automatic model_step(output int cyc, output int opc);
    logic [W-1:0] inst;
    logic [N-1:0] a;
    inst = m_mem[m_pc[N-1:0]];
    opc  = int'(inst[W-1:N]);
    a    = inst[N-1:0];
    case (opc)
      0: if (m_acc == '0) begin m_pc = inst; cyc = 5; end
         else begin m_pc = m_pc + 6'd1; cyc = 6; end
      1: begin m_pc = inst; cyc = 4; end
      2: begin m_acc = m_acc + m_mem[a]; m_pc = m_pc + 6'd1; cyc = 8; end
      3: begin m_acc = m_acc - m_mem[a]; m_pc = m_pc + 6'd1; cyc = 8; end
      4: begin m_acc = m_mem[a]; m_pc = m_pc + 6'd1; cyc = 6; end
      5: begin m_mem[a] = m_acc; m_pc = m_pc + 6'd1; cyc = 6; end
      6: begin m_pc = m_pc + 6'd1; cyc = 6; end
      default: begin m_pc = m_pc + 6'd1; cyc = 5; end
    endcase
  endtask

  task automatic run_prog(input int ninstr);
    int seen, since, exp_cyc, last_opc, bad;
    rst = 1'b1;
    @(negedge clk);
    // R1: one reset edge is enough, even mid-instruction
    chk(bnd == 1'b1, "R1", "boundary under reset", int'(bnd), 1);
    chk(ctl == FETCH0, "R1", "strobes under reset", int'(ctl), int'(FETCH0));
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < MD; i++) m_mem[i] = ld_img[i];
    m_pc = '0; m_acc = ld_acc;
    seen = 0; since = 0; exp_cyc = 0; last_opc = 0;
    while (seen <= ninstr) begin
      // R3
      chk((32'(ctl[11]) + 32'(ctl[8]) + 32'(ctl[6]) + 32'(ctl[4]) + 32'(ctl[0])) <= 1,
          "R3", "read strobes", int'(ctl), 0);
      if (bnd) begin
        if (seen > 0) begin
          // R5 R6 R9: boundary returns after the opcode's cycle count
          chk(since + 1 == exp_cyc, "R5 R6 R9", "cycles", since + 1, exp_cyc);
          if (last_opc <= 1)
            chk(pc == m_pc, "R4 R7", "pc", int'(pc), int'(m_pc));
          else
            chk(pc == m_pc, "R10", "pc", int'(pc), int'(m_pc));
          chk(acc == m_acc, (last_opc >= 6) ? "R10" : "R8", "acc", int'(acc), int'(m_acc));
          bad = -1;
          for (int i = MD - 1; i >= 0; i--) if (mem[i] != m_mem[i]) bad = i;
          if (bad < 0) chk(1'b1, "R8", "memory", 0, 0);
          else chk(1'b0, "R8", $sformatf("memory word %0d", bad),
                   int'(mem[bad]), int'(m_mem[bad]));
        end
        chk(ctl == FETCH0, "R2", "boundary strobes", int'(ctl), int'(FETCH0));
        model_step(exp_cyc, last_opc);
        seen++;
        since = 0;
      end else begin
        since++;
        if (since == 1)
          chk(ctl == FETCH1, "R2", "second fetch strobes", int'(ctl), int'(FETCH1));
        if (since > 12) begin
          chk(1'b0, "R9", "boundary missing", since, exp_cyc);
          break;
        end
      end
      @(negedge clk);
    end
    repeat (3) @(negedge clk);  // next reset lands mid-instruction
  endtask

  logic [15:0] lf = 16'hACE1;
  function automatic logic [15:0] lstep(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    for (int i = 0; i < MD; i++) ld_img[i] = '0;
    ld_acc = '0;
    // directed sweep: every opcode, operand address, zero / nonzero ACC
    for (int opc = 0; opc < 8; opc++)
      for (int z = 0; z < 2; z++)
        for (int a = 0; a < MD; a++) begin
          for (int i = 1; i < MD; i++) ld_img[i] = 6'((i * 11 + opc * 5 + a) % 64);
          ld_img[0] = {3'(opc), 3'(a)};
          ld_acc = (z == 1) ? 6'd0 : 6'(((a * 9 + opc) % 32) + 1);
          run_prog(2);
        end
    // seeded programs, including self-modifying code and PC wrap
    for (int p = 0; p < 60; p++) begin
      for (int i = 0; i < MD; i++) begin
        lf = lstep(lf);
        ld_img[i] = lf[5:0];
      end
      lf = lstep(lf);
      ld_acc = (lf[0]) ? 6'd0 : lf[11:6];
      run_prog(30);
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule